// File: doc/BRIEF.md
# Double-Buffer Swap Controller

This block chooses which of two frame buffers a display refresh engine reads. It keeps its own field timing from a timing tick. It emits a one-clock begin-of-field pulse when the active field starts and a one-clock end-of-field pulse when the active field ends. The short vertical retrace gap lies between these two events. Software draws into the hidden buffer and then strobes a swap request. The block holds that request until retrace and only then flips the buffer select, so the select never changes in the middle of a field.

The flip also sets a sticky swap-done flag. Software therefore knows the new buffer is really being scanned and need not infer it from field timing. The flag stays set until software acknowledges it. A flip that coincides with an acknowledge keeps the flag set, so a completion event is never lost to a racing clear.

Several requests made before the flip merge into a single flip.

The field timer has two states: `FLD_ACTIVE` (the visible field) and `FLD_RETRACE` (the gap).
- Transition `FLD_ACTIVE -> FLD_RETRACE` happens on the tick that completes `ACTIVE_TICKS` ticks of the field. It raises `eof_o`.
- Transition `FLD_RETRACE -> FLD_ACTIVE` happens on the tick that completes `GAP_TICKS` ticks of the gap. It raises `bof_o`.

The swap state machine has two states: `SW_IDLE` (nothing waiting) and `SW_PENDING` (a request is held).
- Transition `SW_IDLE -> SW_PENDING` happens when a request arrives during the active field.
- Transition `SW_PENDING -> SW_IDLE` is the apply transition. It happens on any clock spent in retrace and flips the select.
- A request that arrives in retrace while in `SW_IDLE` applies at once and the machine stays in `SW_IDLE`.

The defaults, 16760 ticks of field and 4 ticks of gap, suit a 1 µs tick.

Top module: `dbl_buf_swap`

## Requirements
- R1: During and right after reset, `buf_sel_o`, `bof_o`, `eof_o` and `swap_done_o` are 0, and the timer starts at the first tick count of an active field.
- R2: Only clock cycles with `tick_i` high advance the timer. The active field spans `ACTIVE_TICKS` ticks and the retrace gap spans `GAP_TICKS` ticks. With a tick every clock, consecutive `bof_o` pulses are `ACTIVE_TICKS+GAP_TICKS` clocks apart.
- R3: `eof_o` is high for exactly the first clock of each retrace gap, and `bof_o` for exactly the first clock of each active field. The two are never high together.
- R4: A request strobed during the active field is held. `buf_sel_o` shows the new value in the clock after the one in which `eof_o` is high.
- R5: A request strobed in a clock spent in retrace flips `buf_sel_o` so that the new value shows in the following clock.
- R6: Any number of requests made before a flip is applied produce exactly one flip.
- R7: `buf_sel_o` changes only at the end of a clock spent in retrace.
- R8: `swap_done_o` becomes 1 in the same clock in which the new `buf_sel_o` value first shows, and then stays 1 until acknowledged.
- R9: `done_ack_i` high for a clock clears `swap_done_o` from the next clock on. An acknowledge while the flag is clear has no effect.
- R10: If a flip and an acknowledge fall in the same clock, `swap_done_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timing tick; advances the field timer by one count |
| swap_req_i | input | 1 | Strobe asking to show the other buffer |
| done_ack_i | input | 1 | Strobe clearing the swap-done flag |
| buf_sel_o | output | 1 | Index of the buffer being displayed |
| bof_o | output | 1 | One-clock pulse at the start of an active field |
| eof_o | output | 1 | One-clock pulse at the start of retrace |
| swap_done_o | output | 1 | Sticky flag: a flip has taken effect |

## Verification
The assertions check the following on every clock:
- the field events are exclusive and each matches the timer phase;
- the select moves only out of a retrace clock;
- every flip raises the done flag;
- the flag rises only with a flip and falls only after an acknowledge;
- a request made in retrace is applied at once.

Only the bench scenarios can show the properties that need timing and counting over whole fields. These are the exact field and gap lengths under dense and sparse ticks, the deferral of an active-field request to the clock after `eof_o`, the merging of several requests into one flip, and the collision of an acknowledge with a flip.

// File: rtl/dbl_buf_swap_pkg.sv
package dbl_buf_swap_pkg;

    typedef enum logic {
        FLD_ACTIVE  = 1'b0,
        FLD_RETRACE = 1'b1
    } fld_state_e;

    typedef enum logic {
        SW_IDLE    = 1'b0,
        SW_PENDING = 1'b1
    } sw_state_e;

    function automatic int cnt_bits(input int a, input int b);
        int m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m);
    endfunction

endpackage

// File: rtl/dbl_buf_field_timer.sv
module dbl_buf_field_timer
    import dbl_buf_swap_pkg::*;
#(
    parameter int ACTIVE_TICKS = 16760,
    parameter int GAP_TICKS    = 4,
    parameter int CW           = cnt_bits(ACTIVE_TICKS, GAP_TICKS)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    output logic retrace_o,
    output logic bof_o,
    output logic eof_o
);

    localparam logic [CW-1:0] LAST_ACT = CW'(ACTIVE_TICKS - 1);
    localparam logic [CW-1:0] LAST_GAP = CW'(GAP_TICKS - 1);

    fld_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          wrap;
    logic          bof_q, eof_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        wrap    = 1'b0;
        unique case (state_q)
            FLD_ACTIVE:  wrap = tick_i && (cnt_q == LAST_ACT);
            FLD_RETRACE: wrap = tick_i && (cnt_q == LAST_GAP);
            default:     wrap = 1'b0;
        endcase
        if (tick_i) begin
            if (wrap) begin
                cnt_d   = '0;
                state_d = (state_q == FLD_ACTIVE) ? FLD_RETRACE : FLD_ACTIVE;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= FLD_ACTIVE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // registered field events
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            bof_q <= 1'b0;
            eof_q <= 1'b0;
        end else begin
            bof_q <= wrap && (state_q == FLD_RETRACE);
            eof_q <= wrap && (state_q == FLD_ACTIVE);
        end
    end

    assign retrace_o = (state_q == FLD_RETRACE);
    assign bof_o     = bof_q;
    assign eof_o     = eof_q;

endmodule

// File: rtl/dbl_buf_swap_fsm.sv
module dbl_buf_swap_fsm
    import dbl_buf_swap_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic retrace_i,
    input  logic req_i,
    output logic apply_o,
    output logic buf_sel_o
);

    sw_state_e state_q, state_d;
    logic      apply;
    logic      sel_q;

    // next-state logic: a retrace clock applies anything waiting
    always_comb begin
        state_d = state_q;
        apply   = 1'b0;
        unique case (state_q)
            SW_IDLE: begin
                if (req_i) begin
                    if (retrace_i) apply = 1'b1;
                    else           state_d = SW_PENDING;
                end
            end
            SW_PENDING: begin
                if (retrace_i) begin
                    apply   = 1'b1;
                    state_d = SW_IDLE;
                end
            end
            default: state_d = SW_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= SW_IDLE;
        else         state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk_i) begin
        if (!rst_ni)    sel_q <= 1'b0;
        else if (apply) sel_q <= ~sel_q;
    end

    assign apply_o   = apply;
    assign buf_sel_o = sel_q;

endmodule

// File: rtl/dbl_buf_done_flag.sv
module dbl_buf_done_flag (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    // set has priority over clear so a completion is never lost
    always_ff @(posedge clk_i) begin
        if (!rst_ni)     flag_q <= 1'b0;
        else if (set_i)  flag_q <= 1'b1;
        else if (clr_i)  flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/dbl_buf_swap.sv
module dbl_buf_swap
    import dbl_buf_swap_pkg::*;
#(
    parameter int ACTIVE_TICKS = 16760,
    parameter int GAP_TICKS    = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic swap_req_i,
    input  logic done_ack_i,
    output logic buf_sel_o,
    output logic bof_o,
    output logic eof_o,
    output logic swap_done_o
);

    localparam int CW = cnt_bits(ACTIVE_TICKS, GAP_TICKS);

    logic retrace_w;
    logic apply_w;

    dbl_buf_field_timer #(
        .ACTIVE_TICKS(ACTIVE_TICKS),
        .GAP_TICKS   (GAP_TICKS),
        .CW          (CW)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .retrace_o(retrace_w),
        .bof_o    (bof_o),
        .eof_o    (eof_o)
    );

    dbl_buf_swap_fsm u_swap (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .retrace_i(retrace_w),
        .req_i    (swap_req_i),
        .apply_o  (apply_w),
        .buf_sel_o(buf_sel_o)
    );

    dbl_buf_done_flag u_done (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .set_i (apply_w),
        .clr_i (done_ack_i),
        .flag_o(swap_done_o)
    );

endmodule

// File: rtl/dbl_buf_swap_chk.sv
module dbl_buf_swap_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic retrace_i,
    input logic swap_req_i,
    input logic done_ack_i,
    input logic buf_sel_o,
    input logic bof_o,
    input logic eof_o,
    input logic swap_done_o
);

    a_r3_events_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bof_o && eof_o));

    a_r3_eof_in_retrace: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eof_o |-> retrace_i);

    a_r3_bof_in_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bof_o |-> !retrace_i);

    a_r5_retrace_req_applied: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (retrace_i && swap_req_i) |=> !$stable(buf_sel_o));

    a_r7_flip_from_retrace: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(buf_sel_o) |-> $past(retrace_i));

    a_r8_flip_sets_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(buf_sel_o) |-> swap_done_o);

    a_r8_done_rises_with_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(swap_done_o) |-> !$stable(buf_sel_o));

    a_r9_done_falls_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(swap_done_o) |-> $past(done_ack_i));

endmodule

bind dbl_buf_swap dbl_buf_swap_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .retrace_i  (retrace_w),
    .swap_req_i (swap_req_i),
    .done_ack_i (done_ack_i),
    .buf_sel_o  (buf_sel_o),
    .bof_o      (bof_o),
    .eof_o      (eof_o),
    .swap_done_o(swap_done_o)
);

// File: tb/sim_dbl_buf_swap.sv
`timescale 1ns/1ps
module sim_dbl_buf_swap;

    localparam int ACT = 12;
    localparam int GAP = 3;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic tick = 1'b0, req = 1'b0, ack = 1'b0;
    logic buf_sel, bof, eof, done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string cur_tag = "R7";

    // reference state
    bit m_ret, m_pend, m_sel, m_done, m_bof, m_eof;
    int m_cnt;

    always #10 clk = ~clk;

    dbl_buf_swap #(.ACTIVE_TICKS(ACT), .GAP_TICKS(GAP)) u0 (
        .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .swap_req_i(req),
        .done_ack_i(ack), .buf_sel_o(buf_sel), .bof_o(bof), .eof_o(eof),
        .swap_done_o(done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit ends_phase(input bit ret, input int cnt);
        return ret ? (cnt == GAP - 1) : (cnt == ACT - 1);
    endfunction

    // one clock: drive, edge, update reference, compare
    task automatic cyc(input bit t, input bit r, input bit a);
        bit apply, fin;
        tick = t; req = r; ack = a;
        @(posedge clk);
        apply = m_ret && (m_pend || r);
        fin   = t && ends_phase(m_ret, m_cnt);
        m_bof = fin && m_ret;
        m_eof = fin && !m_ret;
        m_pend = apply ? 1'b0 : (r ? 1'b1 : m_pend);
        m_sel  = m_sel ^ apply;
        m_done = apply ? 1'b1 : (a ? 1'b0 : m_done);
        if (t) begin
            if (fin) begin m_cnt = 0; m_ret = !m_ret; end
            else m_cnt++;
        end
        #2;
        chk("R3", {bof, eof}, {m_bof, m_eof});
        chk(cur_tag, buf_sel, m_sel);
        chk("R8", done, m_done);
        tick = 0; req = 0; ack = 0;
    endtask

    task automatic wait_bof();
        for (int i = 0; i < 200; i++) begin
            cyc(1, 0, 0);
            if (bof) break;
        end
    endtask

    task automatic wait_eof();
        for (int i = 0; i < 200; i++) begin
            cyc(1, 0, 0);
            if (eof) break;
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        if (!finished) $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit old;
        int t0, n, ntog;
        void'($urandom(32'h5a17));
        repeat (3) @(posedge clk);
        #2;
        chk("R1", {buf_sel, bof, eof, done}, 0);
        rst_ni = 1'b1;
        m_ret = 0; m_cnt = 0; m_pend = 0; m_sel = 0; m_done = 0; m_bof = 0; m_eof = 0;
        cyc(0, 0, 0);
        chk("R1", {buf_sel, bof, eof, done}, 0);

        // R2: field period with dense ticks
        cur_tag = "R2";
        wait_bof(); t0 = 0;
        for (int i = 0; i < 200; i++) begin cyc(1, 0, 0); t0++; if (bof) break; end
        chk("R2", t0, ACT + GAP);
        // R2: sparse ticks, one every other clock
        wait_bof(); t0 = 0;
        for (int i = 0; i < 400; i++) begin cyc(i % 2, 0, 0); t0++; if (bof) break; end
        chk("R2", t0, 2 * (ACT + GAP));

        // R4: request in active field applies after eof
        cur_tag = "R4";
        wait_bof(); cyc(1, 0, 0);
        old = buf_sel;
        cyc(1, 1, 0);
        wait_eof();
        chk("R4", buf_sel, old);
        cyc(1, 0, 0);
        chk("R4", buf_sel, !old);
        cyc(1, 0, 1);
        chk("R9", done, 0);
        cyc(1, 0, 1);
        chk("R9", done, 0);

        // R5: request inside retrace applies on the next clock
        cur_tag = "R5";
        wait_eof();
        old = buf_sel;
        cyc(1, 1, 0);
        chk("R5", buf_sel, !old);
        chk("R8", done, 1);
        for (int i = 0; i < 5; i++) cyc(1, 0, 0);
        chk("R8", done, 1);

        // R10: flip and acknowledge in the same clock
        cur_tag = "R10";
        wait_eof();
        old = buf_sel;
        cyc(1, 1, 1);
        chk("R10", done, 1);
        chk("R10", buf_sel, !old);
        cyc(0, 0, 1);
        chk("R9", done, 0);

        // R6: several requests merge into one flip
        cur_tag = "R6";
        wait_bof();
        old = buf_sel; ntog = 0;
        cyc(1, 1, 0); cyc(1, 0, 0); cyc(1, 1, 0); cyc(1, 1, 0);
        for (int i = 0; i < ACT + GAP; i++) begin
            bit prev;
            prev = buf_sel;
            cyc(1, 0, 0);
            if (buf_sel != prev) ntog++;
        end
        chk("R6", ntog, 1);

        // R7: random traffic against the reference
        cur_tag = "R7";
        n = 0;
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 4) != 0, ($urandom % 16) == 0, ($urandom % 8) == 0);
            n++;
        end
        chk("R7", n, 4000);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule